// File: doc/BRIEF.md
# DMA Interrupt Mask and Latch Controller

This block gathers the error and event pulses of a script-driven DMA engine into a read-to-clear status register. It drives one active-low interrupt line through a per-source enable mask. Six sources are defined: illegal instruction, script interrupt instruction, single step, abort, bus fault and master data parity error. Each source is a single-cycle pulse on the event bus, at the same bit position it takes in the status and enable registers.

The enable mask controls only the interrupt pin. A masked event still sets its status bit, raises the pending flag and stops the script sequencer. Every DMA source counts as fatal. Once the interrupt line is low it stays low until software reads the status register; changing the mask does not release it.

Status is kept stable while stacking is in force. Stacking is in force while DMA status is pending or while an external SCSI interrupt is pending. New events during that time are merged into one queued word, which moves into the status register after the pending condition clears. The register port uses plain strobes and has no back-pressure: every write or read strobe completes in the cycle it is presented, and the read data is valid in that same cycle.

Top module: `dma_irq_ctl`

## Requirements
- R1: After reset (asynchronous, active low) the enable register reads 0, status reads 0, `irq_n_o` is 1, and `dma_pend_o` and `halt_o` are 0.
- R2: A write with `reg_addr_i`=0 loads the enable register. Only bits 6,5,4,3,2,0 are stored, and bits 7 and 1 read as 0. A read with `reg_addr_i`=0 returns the enable value combinationally and has no side effect.
- R3: An event pulse on bit 6,5,4,3,2 or 0 of `evt_i` sets the same status bit at the next clock edge whatever its enable bit holds, provided stacking is not in force. Pulses on bits 7 and 1 are ignored.
- R4: `dma_pend_o` is 1 exactly while any status bit is set, whether or not that bit is enabled.
- R5: `halt_o` is 1 while any status bit or queued bit is set, whether or not it is enabled.
- R6: When a status bit and its enable bit are both 1, `irq_n_o` goes low at the next clock edge.
- R7: Once low, `irq_n_o` stays low until a status read; clearing enable bits does not release it.
- R8: A set status bit whose enable is 0 does not prevent another set, enabled status bit from driving `irq_n_o` low.
- R9: While status is nonzero or `scsi_pend_i` is 1, new events are ORed into one queued word and the status register does not change except by a read. The queued word loads into status on the first edge at which status is 0 and `scsi_pend_i` is 0.
- R10: A read with `reg_addr_i`=1 returns the current status in the same cycle. It clears status and releases `irq_n_o` at that clock edge. A queued word loads on the following edge, and `irq_n_o` falls again one edge later if that word has an enabled bit.
- R11: An event arriving in the same cycle as a status read is not lost: it appears in status, directly or through the queue.
- R12: A write with `reg_addr_i`=1 has no effect on status or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Single-cycle DMA event pulses, one bit per source |
| scsi_pend_i | input | 1 | External SCSI interrupt pending, holds stacking |
| reg_addr_i | input | 1 | 0 = enable register, 1 = status register |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| irq_n_o | output | 1 | Latched active-low interrupt |
| dma_pend_o | output | 1 | Any DMA status bit set |
| halt_o | output | 1 | Stop request to the script sequencer |

## Verification
The bench goes after four mask corners. A masked event must still show up in status, pending and halt; a design that gated capture with the mask would leave all three low. An enable is cleared while the line is low; a design that evaluated the mask live would release the line early. A read is made while a queued word waits, both with and without the external SCSI flag held; a design with the wrong drain timing would lose the word or load it over unread status. Finally an event lands in the same cycle as a status read, which a design that gave the clear priority would drop.

// File: rtl/dint_pkg.sv
package dint_pkg;
  localparam int          DINT_W       = 8;
  localparam logic [7:0]  DINT_SRC_MSK = 8'h7D;  // bits 6,5,4,3,2,0 are real sources
  localparam logic        DINT_A_EN    = 1'b0;
  localparam logic        DINT_A_STAT  = 1'b1;
endpackage

// File: rtl/dint_enable.sv
module dint_enable #(
  parameter int           W   = 8,
  parameter logic [W-1:0] MSK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_o <= '0;
    else if (wr_i) en_o <= wdata_i & MSK;
  end

  AST_EN_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((en_o & ~MSK) == '0));  // R2
endmodule

// File: rtl/dint_status.sv
module dint_status #(
  parameter int           W   = 8,
  parameter logic [W-1:0] MSK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         scsi_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o,
  output logic         stk_v_o
);
  logic [W-1:0] ev;
  logic [W-1:0] stk_q, stk_n, stat_n;
  logic         stk_v_n, act;

  assign ev  = evt_i & MSK;
  assign act = (stat_o != '0) | scsi_i;

  always_comb begin
    stat_n  = stat_o;
    stk_n   = stk_q;
    stk_v_n = stk_v_o;
    if (act) begin
      if (clr_i) stat_n = '0;
      if (ev != '0) begin
        stk_n   = stk_q | ev;
        stk_v_n = 1'b1;
      end
    end else begin
      stat_n  = (stk_v_o ? stk_q : '0) | ev;
      stk_n   = '0;
      stk_v_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o  <= '0;
      stk_q   <= '0;
      stk_v_o <= 1'b0;
    end else begin
      stat_o  <= stat_n;
      stk_q   <= stk_n;
      stk_v_o <= stk_v_n;
    end
  end

  AST_CAPTURE_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && ev != '0) |=> ((stat_o & $past(ev)) == $past(ev)));  // R3
  AST_STACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o != '0 && !clr_i) |=> $stable(stat_o));  // R9
  AST_NO_EVENT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> (((stat_o | stk_q) & $past(ev)) == $past(ev)));  // R11
endmodule

// File: rtl/dint_latch.sv
module dint_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  output logic         irq_o
);
  logic fire;
  assign fire = (stat_i & en_i) != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_o <= 1'b0;
    else if (clr_i) irq_o <= 1'b0;
    else if (fire)  irq_o <= 1'b1;
  end

  AST_IRQ_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr_i) |=> irq_o);  // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o);  // R7
  AST_IRQ_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !irq_o);  // R10
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
  import dint_pkg::*;
#(
  parameter int           W   = DINT_W,
  parameter logic [W-1:0] MSK = DINT_SRC_MSK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         scsi_pend_i,
  input  logic         reg_addr_i,
  input  logic         reg_wr_i,
  input  logic         reg_rd_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  output logic         irq_n_o,
  output logic         dma_pend_o,
  output logic         halt_o
);
  logic [W-1:0] en, stat;
  logic         stk_v, irq, rd_stat, wr_en;

  assign rd_stat = reg_rd_i & (reg_addr_i == DINT_A_STAT);
  assign wr_en   = reg_wr_i & (reg_addr_i == DINT_A_EN);

  dint_enable #(.W(W), .MSK(MSK)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .wdata_i(reg_wdata_i), .en_o(en));

  dint_status #(.W(W), .MSK(MSK)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .scsi_i(scsi_pend_i),
    .clr_i(rd_stat), .stat_o(stat), .stk_v_o(stk_v));

  dint_latch #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat_i(stat), .en_i(en),
    .clr_i(rd_stat), .irq_o(irq));

  assign reg_rdata_o = (reg_addr_i == DINT_A_STAT) ? stat : en;
  assign irq_n_o     = ~irq;
  assign dma_pend_o  = stat != '0;
  assign halt_o      = dma_pend_o | stk_v;

  AST_HALT_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & MSK) != '0) |=> halt_o);  // R5
  AST_PEND_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_pend_o && !scsi_pend_i && (evt_i & MSK) != '0) |=> dma_pend_o);  // R4
endmodule

// File: tb/tb_dma_irq_ctl.sv
module tb_dma_irq_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0;
  logic       scsi_pend_i = 1'b0;
  logic       reg_addr_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic       reg_rd_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_n_o, dma_pend_o, halt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  dma_irq_ctl dut (.*);

  // {ev, scsi, rd, wr, addr, wdata, exp_rdata, exp_irq_n, exp_pend, exp_halt, req}
  localparam int NV = 32;
  localparam logic [34:0] VEC [NV] = '{
    {8'h00,1'b0,1'b0,1'b1,1'b0,8'hFF, 8'h00,1'b1,1'b0,1'b0,4'd2},  // R2 write all ones
    {8'h00,1'b0,1'b1,1'b0,1'b0,8'h00, 8'h7D,1'b1,1'b0,1'b0,4'd2},  // R2 reserved bits read 0
    {8'h00,1'b0,1'b0,1'b1,1'b0,8'h04, 8'h7D,1'b1,1'b0,1'b0,4'd2},  // R2
    {8'h40,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h04,1'b1,1'b1,1'b1,4'd4},  // R4 masked event pends
    {8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h04,1'b1,1'b1,1'b1,4'd6},  // R6 masked: no irq
    {8'h00,1'b0,1'b1,1'b0,1'b1,8'h00, 8'h40,1'b1,1'b0,1'b0,4'd10}, // R10 read clears
    {8'h04,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h00,1'b1,1'b1,1'b1,4'd3},  // R3 capture
    {8'h40,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h04,1'b0,1'b1,1'b1,4'd6},  // R6 fires, 0x40 queued
    {8'h00,1'b0,1'b0,1'b1,1'b0,8'h00, 8'h04,1'b0,1'b1,1'b1,4'd7},  // R7 disable all
    {8'h00,1'b0,1'b0,1'b0,1'b0,8'h00, 8'h00,1'b0,1'b1,1'b1,4'd7},  // R7 still low
    {8'h00,1'b0,1'b0,1'b1,1'b0,8'h40, 8'h00,1'b0,1'b1,1'b1,4'd7},  // R7
    {8'h00,1'b0,1'b1,1'b0,1'b1,8'h00, 8'h04,1'b1,1'b0,1'b1,4'd10}, // R10 read, queue waits
    {8'h00,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h00,1'b1,1'b1,1'b1,4'd10}, // R10 queue loads
    {8'h00,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h40,1'b0,1'b1,1'b1,4'd10}, // R10 re-asserts
    {8'h01,1'b0,1'b1,1'b0,1'b1,8'h00, 8'h40,1'b1,1'b0,1'b1,4'd11}, // R11 event with read
    {8'h00,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h00,1'b1,1'b1,1'b1,4'd11}, // R11
    {8'h00,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h01,1'b1,1'b1,1'b1,4'd11}, // R11 kept
    {8'h00,1'b0,1'b1,1'b0,1'b1,8'h00, 8'h01,1'b1,1'b0,1'b0,4'd10}, // R10
    {8'h82,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h00,1'b1,1'b0,1'b0,4'd3},  // R3 reserved events ignored
    {8'h00,1'b0,1'b0,1'b1,1'b1,8'hFF, 8'h00,1'b1,1'b0,1'b0,4'd12}, // R12 status write ignored
    {8'h08,1'b0,1'b1,1'b0,1'b1,8'h00, 8'h00,1'b1,1'b1,1'b1,4'd11}, // R11 event on empty read
    {8'h20,1'b1,1'b0,1'b0,1'b1,8'h00, 8'h08,1'b1,1'b1,1'b1,4'd9},  // R9 queued
    {8'h00,1'b1,1'b1,1'b0,1'b1,8'h00, 8'h08,1'b1,1'b0,1'b1,4'd9},  // R9 read under SCSI
    {8'h00,1'b1,1'b0,1'b0,1'b1,8'h00, 8'h00,1'b1,1'b0,1'b1,4'd5},  // R5 halt on queue only
    {8'h00,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h00,1'b1,1'b1,1'b1,4'd9},  // R9 drains
    {8'h00,1'b0,1'b0,1'b1,1'b0,8'h20, 8'h40,1'b1,1'b1,1'b1,4'd2},  // R2
    {8'h00,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h20,1'b0,1'b1,1'b1,4'd6},  // R6 late enable fires
    {8'h00,1'b0,1'b1,1'b0,1'b1,8'h00, 8'h20,1'b1,1'b0,1'b0,4'd10}, // R10
    {8'h00,1'b0,1'b0,1'b1,1'b0,8'h08, 8'h20,1'b1,1'b0,1'b0,4'd2},  // R2
    {8'h48,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h00,1'b1,1'b1,1'b1,4'd8},  // R8 mixed event
    {8'h00,1'b0,1'b0,1'b0,1'b1,8'h00, 8'h48,1'b0,1'b1,1'b1,4'd8},  // R8 unmasked wins
    {8'h00,1'b0,1'b1,1'b0,1'b1,8'h00, 8'h48,1'b1,1'b0,1'b0,4'd8}   // R8
  };

  task automatic check(input int req, input logic [10:0] got, input logic [10:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got rdata/irq_n/pend/halt=%h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    evt_i = '0; scsi_pend_i = 0; reg_rd_i = 0; reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd0, rd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at both addresses
    reg_addr_i = 0; #1 rd0 = reg_rdata_o;
    reg_addr_i = 1; #1 rd1 = reg_rdata_o;
    check(1, {rd0 | rd1, irq_n_o, dma_pend_o, halt_o}, {8'h00, 1'b1, 1'b0, 1'b0});
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      logic [7:0]  got_rd;
      v = VEC[i];
      evt_i = v[34:27]; scsi_pend_i = v[26]; reg_rd_i = v[25]; reg_wr_i = v[24];
      reg_addr_i = v[23]; reg_wdata_i = v[22:15];
      #1 got_rd = reg_rdata_o;
      @(negedge clk);
      check(int'(v[3:0]), {got_rd, irq_n_o, dma_pend_o, halt_o}, v[14:4]);
    end

    // R1: reset in the middle of an active interrupt
    idle(); reg_addr_i = 0; reg_wr_i = 1; reg_wdata_i = 8'h04;
    @(negedge clk); idle(); evt_i = 8'h04;
    @(negedge clk); idle();
    @(negedge clk);
    check(6, {8'h00, irq_n_o, dma_pend_o, halt_o}, {8'h00, 1'b0, 1'b1, 1'b1});  // R6
    #1 rst_n = 1'b0;
    #1 reg_addr_i = 0;
    #1 rd0 = reg_rdata_o;
    check(1, {rd0, irq_n_o, dma_pend_o, halt_o}, {8'h00, 1'b1, 1'b0, 1'b0});    // R1
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R3: after reset, a masked event still captures
    evt_i = 8'h10; reg_addr_i = 1;
    @(negedge clk); idle();
    #1 rd1 = reg_rdata_o;
    check(3, {rd1, irq_n_o, dma_pend_o, halt_o}, {8'h10, 1'b1, 1'b1, 1'b1});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule